// File: doc/BRIEF.md
# Aligned-Block Byte Copy Engine

The engine copies a run of bytes from the CPU address space to one of two fixed destination ports: the sprite-attribute port or the video-memory port. Software first writes a settings byte that selects the destination, a length code and the upper nibble of the source low byte. It then writes the source high byte, and that write starts the copy. While the copy runs, the engine holds the CPU stalled. Each byte takes one read cycle on the memory port, followed by one write cycle on the destination port.

The address space is divided into naturally aligned blocks of the selected length. A copy runs from its start address up to the last byte of the block that holds that start address, and then stops. A start address that is not on a block boundary therefore moves fewer bytes than the selected length. The source low nibble is always zero, so a start address lies on a 16-byte boundary.

Top module: `blkdma_top`

## Requirements
- R1: After reset, `stall`, `mem_re` and `dst_we` are all low.
- R2: The first read of a copy uses address {`go_wdata`, settings bits 7..4, 4'b0000}.
- R3: Settings bit 0 chooses the destination. The value on `dst_sel` is 0 for the sprite port and 1 for the video port, and it holds for every write of the copy.
- R4: Settings bits 3..1 encode the block length: 100=16, 101=32, 110=64, 111=128, 000=256 bytes. Codes 001, 010 and 011 also give 256 bytes.
- R5: A copy ends after it writes the byte whose low address bits (under mask length-1) are all ones. It moves length − (start low byte mod length) bytes and never leaves its 256-byte page.
- R6: Every byte takes a read cycle (`mem_re` high, `mem_addr` = source address) and then a write cycle (`dst_we` high, `dst_wdata` = the byte read in that read cycle). Source addresses rise by one from byte to byte.
- R7: `stall` rises in the cycle after the start write. It stays high for exactly 2 × byte-count cycles and falls after the final write cycle.
- R8: A start write while a copy is active is ignored, and the running copy is not changed.
- R9: A settings write during a copy does not alter that copy's length or destination. The new value is used by the next copy.
- R10: `mem_re` and `dst_we` are never high together, and both are low whenever `stall` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Settings register write strobe |
| cfg_wdata | input | 8 | Settings value: [7:4] source low nibble, [3:1] length code, [0] destination |
| go_we | input | 1 | Source-high write strobe; starts a copy when idle |
| go_wdata | input | ADDR_W-8 | Source high byte |
| mem_re | output | 1 | Memory read strobe |
| mem_addr | output | ADDR_W | Memory read address |
| mem_rdata | input | 8 | Read data for `mem_addr`, valid in the same cycle |
| dst_we | output | 1 | Destination write strobe |
| dst_sel | output | 1 | Destination: 0 sprite port, 1 video port |
| dst_wdata | output | 8 | Destination write data |
| stall | output | 1 | CPU stall request |

## Verification
The assertions take three things about the inputs as given. A settings write and a start write never fall in the same cycle. `mem_rdata` settles during the read cycle for the address on `mem_addr`. Each write strobe is a single-cycle pulse. The stimulus drives every strobe on the falling edge and holds it for exactly one cycle, always puts the settings write before the start write, and models the memory as a combinational function of the address. Writes that land during an active copy are placed deliberately, in both read and write cycles, so that the assertions on ignored starts and frozen settings are exercised.

// File: rtl/blkdma_pkg.sv
package blkdma_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } st_e;

  // settings byte layout: [7:4] source low nibble, [3:1] length code, [0] target
  typedef struct packed {
    logic [3:0] lo_nib;
    logic [2:0] len_code;
    logic       to_video;
  } cfg_t;

  // block length minus one, as a mask on the low address byte
  function automatic logic [7:0] blk_mask(input logic [2:0] code);
    logic [7:0] m;
    case (code)
      3'b100:  m = 8'h0F;
      3'b101:  m = 8'h1F;
      3'b110:  m = 8'h3F;
      3'b111:  m = 8'h7F;
      default: m = 8'hFF;
    endcase
    return m;
  endfunction

  // true when the low byte sits on the final byte of its aligned block
  function automatic logic blk_last(input logic [7:0] lo, input logic [7:0] mask);
    return (lo & mask) == mask;
  endfunction

endpackage

// File: rtl/blkdma_cfg_reg.sv
module blkdma_cfg_reg
  import blkdma_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [7:0] cfg_wdata,
  input  logic       capture,
  output cfg_t       act_cfg
);

  cfg_t reg_q;
  cfg_t act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_q <= '0;
      act_q <= '0;
    end else begin
      if (cfg_we)  reg_q <= cfg_t'(cfg_wdata);
      if (capture) act_q <= reg_q;
    end
  end

  assign act_cfg = act_q;

  // R9
  snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(capture) |-> $stable(act_q));

endmodule

// File: rtl/blkdma_addr_gen.sv
module blkdma_addr_gen
  import blkdma_pkg::*;
#(
  parameter int ADDR_W = 16,
  localparam int HI_W  = ADDR_W - 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic [HI_W-1:0]   hi_byte,
  input  logic [3:0]        lo_nib,
  input  logic [7:0]        mask,
  output logic [ADDR_W-1:0] addr,
  output logic              at_last
);

  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (load) begin
      addr_q <= {hi_byte, lo_nib, 4'b0000};
    end else if (step) begin
      addr_q[7:0] <= addr_q[7:0] + 8'd1;
    end
  end

  assign addr    = addr_q;
  assign at_last = blk_last(addr_q[7:0], mask);

  // R6
  step_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> addr_q[7:0] == $past(addr_q[7:0]) + 8'd1);

  // R5
  no_page_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> addr_q[7:0] != 8'hFF);

  // R2
  load_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> addr_q[3:0] == 4'b0000);

endmodule

// File: rtl/blkdma_ctrl.sv
module blkdma_ctrl
  import blkdma_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic       at_last,
  input  logic [7:0] mem_rdata,
  output logic       load,
  output logic       step,
  output logic       rd_cyc,
  output logic       wr_cyc,
  output logic       busy,
  output logic [7:0] wdata
);

  st_e        st_q, st_d;
  logic [7:0] data_q;
  logic       start_ok;
  logic       finish;

  assign start_ok = go && (st_q == ST_IDLE);
  assign finish   = (st_q == ST_WRITE) && at_last;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:  if (start_ok) st_d = ST_READ;
      ST_READ:  st_d = ST_WRITE;
      ST_WRITE: st_d = at_last ? ST_IDLE : ST_READ;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      data_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_READ) data_q <= mem_rdata;
    end
  end

  assign load   = start_ok;
  assign step   = (st_q == ST_WRITE) && !at_last;
  assign rd_cyc = (st_q == ST_READ);
  assign wr_cyc = (st_q == ST_WRITE);
  assign busy   = (st_q != ST_IDLE);
  assign wdata  = data_q;

  // R10
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_cyc && wr_cyc));

  // R6
  wr_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cyc |-> $past(rd_cyc));

  // R7
  stall_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(finish));

  // R7
  stall_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start_ok));

endmodule

// File: rtl/blkdma_top.sv
module blkdma_top
  import blkdma_pkg::*;
#(
  parameter int ADDR_W = 16,
  localparam int HI_W  = ADDR_W - 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_wdata,
  input  logic              go_we,
  input  logic [HI_W-1:0]   go_wdata,
  output logic              mem_re,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rdata,
  output logic              dst_we,
  output logic              dst_sel,
  output logic [7:0]        dst_wdata,
  output logic              stall
);

  cfg_t       act_cfg;
  logic [7:0] cur_mask;
  logic       load_w, step_w, at_last_w;
  logic       rd_w, wr_w, busy_w;
  logic [7:0] wdata_w;

  assign cur_mask = blk_mask(act_cfg.len_code);

  blkdma_cfg_reg u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .capture   (load_w),
    .act_cfg   (act_cfg)
  );

  blkdma_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load_w),
    .step    (step_w),
    .hi_byte (go_wdata),
    .lo_nib  (u_cfg.reg_q.lo_nib),
    .mask    (cur_mask),
    .addr    (mem_addr),
    .at_last (at_last_w)
  );

  blkdma_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (go_we),
    .at_last   (at_last_w),
    .mem_rdata (mem_rdata),
    .load      (load_w),
    .step      (step_w),
    .rd_cyc    (rd_w),
    .wr_cyc    (wr_w),
    .busy      (busy_w),
    .wdata     (wdata_w)
  );

  assign mem_re    = rd_w;
  assign dst_we    = wr_w;
  assign dst_sel   = act_cfg.to_video;
  assign dst_wdata = wdata_w;
  assign stall     = busy_w;

  // R8
  busy_go_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && go_we && !dst_we) |=> $stable(mem_addr));

  // R5
  page_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && $past(stall)) |-> $stable(mem_addr[ADDR_W-1:8]));

  // R3
  sel_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && $past(stall)) |-> $stable(dst_sel));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stall |-> !(mem_re || dst_we));

endmodule

// File: tb/blkdma_top_bench.sv
module blkdma_top_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_wdata = '0;
  logic        go_we = 1'b0;
  logic [7:0]  go_wdata = '0;
  logic        mem_re;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata;
  logic        dst_we;
  logic        dst_sel;
  logic [7:0]  dst_wdata;
  logic        stall;

  int n_chk = 0;
  int n_bad = 0;
  int stall_cnt = 0;
  bit done = 1'b0;

  logic [15:0] q_addr[$];
  logic        q_sel[$];
  logic [7:0]  cfg_model = '0;

  always #2 clk = ~clk;

  // memory model: contents are a fixed function of the address
  function automatic logic [7:0] mem_val(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
  endfunction
  assign mem_rdata = mem_val(mem_addr);

  blkdma_top u_blkdma_top (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .go_we(go_we), .go_wdata(go_wdata), .mem_re(mem_re), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .dst_we(dst_we), .dst_sel(dst_sel),
    .dst_wdata(dst_wdata), .stall(stall)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_cfg(input logic [7:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = v; cfg_model = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse_go(input logic [7:0] hi);
    @(negedge clk);
    go_we = 1'b1; go_wdata = hi;
    @(negedge clk);
    go_we = 1'b0;
  endtask

  // driver: predicts the copy from the requirements, then starts it
  task automatic start_copy(input logic [7:0] hi, output int nbytes);
    int len;
    int lo;
    len = cfg_model[3] ? (16 << cfg_model[2:1]) : 256;  // R4
    lo = {cfg_model[7:4], 4'b0000};                      // R2
    nbytes = len - (lo % len);                           // R5
    for (int i = 0; i < nbytes; i++) begin
      q_addr.push_back({hi, 8'(lo + i)});
      q_sel.push_back(cfg_model[0]);                     // R3
    end
    @(negedge clk);
    stall_cnt = 0;
    go_we = 1'b1; go_wdata = hi;
    @(negedge clk);
    go_we = 1'b0;
    check(stall === 1'b1, "R7 stall rise", int'(stall), 1);
  endtask

  task automatic wait_done(input int nbytes);
    while (stall) @(negedge clk);
    check(stall_cnt == 2 * nbytes, "R7 stall length", stall_cnt, 2 * nbytes);
    check(q_addr.size() == 0, "R5 byte count", nbytes - q_addr.size(), nbytes);
  endtask

  task automatic run(input logic [7:0] cfg, input logic [7:0] hi);
    int n;
    wr_cfg(cfg);
    start_copy(hi, n);
    wait_done(n);
  endtask

  // monitor: compares each destination write with the scoreboard
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (stall) stall_cnt++;
      if (mem_re && dst_we) check(1'b0, "R10 overlap", 1, 0);
      if (!stall && (mem_re || dst_we)) check(1'b0, "R10 idle strobe", 1, 0);
      if (dst_we) begin
        if (q_addr.size() == 0) begin
          check(1'b0, "R5 extra write", int'(mem_addr), 0);
        end else begin
          logic [15:0] ea;
          logic        es;
          ea = q_addr.pop_front();
          es = q_sel.pop_front();
          check(mem_addr == ea, "R6 address", int'(mem_addr), int'(ea));
          check(dst_wdata == mem_val(ea), "R6 data", int'(dst_wdata), int'(mem_val(ea)));
          check(dst_sel == es, "R3 target", int'(dst_sel), int'(es));
        end
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      check(1'b0, "watchdog", cyc, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(stall === 1'b0, "R1 stall", int'(stall), 0);
    check(mem_re === 1'b0, "R1 mem_re", int'(mem_re), 0);
    check(dst_we === 1'b0, "R1 dst_we", int'(dst_we), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run(8'h00, 8'h12);   // R4 code 000: 256 bytes, sprite
    run(8'h39, 8'h20);   // R4 code 100: 16 bytes, video
    run(8'h1A, 8'h31);   // R5 code 101 from 0x10: 16 of 32
    run(8'h4C, 8'h42);   // R4 code 110 aligned: 64
    run(8'h5D, 8'h43);   // R5 code 110 from 0x50: 48
    run(8'h9E, 8'h80);   // R5 code 111 from 0x90: 112
    run(8'hF2, 8'hA5);   // R4 code 001 as 256 from 0xF0: 16
    run(8'hE7, 8'hC3);   // R4 code 011 as 256 from 0xE0: 32

    // R8: start writes during a copy are ignored
    wr_cfg(8'h0E);
    start_copy(8'h40, n);
    repeat (10) @(negedge clk);
    pulse_go(8'h77);
    repeat (3) @(negedge clk);
    pulse_go(8'h13);
    wait_done(n);

    // R9: settings write mid-copy leaves the copy alone, next copy uses it
    wr_cfg(8'h29);
    start_copy(8'h55, n);
    repeat (5) @(negedge clk);
    wr_cfg(8'h0E);
    wait_done(n);
    start_copy(8'h66, n);
    wait_done(n);
    check(n == 128, "R9 new settings length", n, 128);

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule